// File: doc/BRIEF.md
# Two-mode load-to-accumulator executor

This block is a small sequencer that walks a byte-wide program held in an external synchronous memory and carries out a single data-moving instruction plus two control bytes. The load instruction always takes two bytes. The first byte is the opcode, and its least significant bit says how to read the second byte. When that bit is clear, the second byte is a literal that is written into the accumulator. When the bit is set, the second byte selects one of the internal registers, and the value of that register is copied into the accumulator. An operand such as 0x02 therefore means the number two in one form and register C in the other.

The block also recognises a one-byte no-operation code and a one-byte stop code. Any other opcode byte stops the sequencer and raises an illegal flag. A register-mode operand that points outside the register file does the same. A combinational debug port shows any register, so a host can inspect results after the sequencer stops. Registers B, C and D take preset values from a parameter at reset. No instruction writes them, so they act as the sources for register-mode loads.

Top module: `ldmode_core`

## Requirements
- R1: While reset is held low, `imem_addr` is 0, `halted` and `illegal` are 0, register A (index 0) reads 0, and registers 1..3 read their bytes from `REG_INIT`.
- R2: Opcode 0xAA (bits 7..1 = 1010101, bit 0 = 0) followed by operand byte v writes v into A.
- R3: Opcode 0xAB (bits 7..1 = 1010101, bit 0 = 1) followed by operand v in 0..3 copies register v into A (A=0, B=1, C=2, D=3). With v=0, A keeps its value.
- R4: A register-mode operand with any of bits 7..2 set leaves A unchanged, sets `illegal` and `halted`, and leaves `imem_addr` one past the operand byte.
- R5: Opcode 0x00 is a one-byte no-operation. It changes no register and advances the address by one.
- R6: Opcode 0xFF stops the sequencer. `halted` goes to 1, `illegal` stays 0, and `imem_addr` rests one past the stop byte.
- R7: Any opcode other than 0x00, 0xAA, 0xAB and 0xFF sets `illegal` and `halted`, and `imem_addr` rests one past that opcode.
- R8: The memory returns the byte at `imem_addr` one cycle after the address is presented. A no-operation takes 2 cycles and a load takes 4 cycles. The address only ever steps up by one.
- R9: Registers 1..3 keep their preset values for the whole run.
- R10: Once `halted` is 1, it and `imem_addr` stay frozen until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| imem_addr | output | PC_W | Program memory read address (program counter) |
| imem_rdata | input | DATA_W | Byte returned by memory one cycle after the address |
| dbg_sel | input | IDX_W | Register index for the debug read port |
| dbg_data | output | DATA_W | Contents of the selected register |
| halted | output | 1 | Sequencer has stopped |
| illegal | output | 1 | Stop was caused by an illegal opcode or operand |

## Verification
The assertions assume the program memory behaves as a one-cycle synchronous read of `imem_addr`. They also assume that `rst_n` is asserted before the first clock edge, so the program counter and state start from known values. The bench models the memory with a register clocked on the same edge. It fills every unused location with the stop code, so every run ends within a few cycles and the address never wraps. Each program is loaded while reset is held, and the bench reads results only after `halted` is set.

// File: rtl/ldmode_pkg.sv
package ldmode_pkg;
  typedef enum logic [2:0] {
    ST_FETCH_OP   = 3'd0,
    ST_DECODE     = 3'd1,
    ST_FETCH_OPND = 3'd2,
    ST_EXECUTE    = 3'd3,
    ST_HALT       = 3'd4
  } ctl_state_e;

  localparam logic [7:0] OPC_NOP  = 8'h00;
  localparam logic [7:0] OPC_STOP = 8'hFF;
  localparam logic [6:0] LD_STEM  = 7'b1010101;
endpackage

// File: rtl/ldmode_rst_sync.sv
module ldmode_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n_s <= stage_q;
    end
  end
endmodule

// File: rtl/ldmode_regfile.sv
module ldmode_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  parameter logic [NREG*DATA_W-1:0] REG_INIT = '0,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   a_we,
  input  logic [DATA_W-1:0]      a_wdata,
  input  logic [IDX_W-1:0]       src_idx,
  output logic [DATA_W-1:0]      src_data,
  input  logic [IDX_W-1:0]       dbg_idx,
  output logic [DATA_W-1:0]      dbg_data,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  logic [NREG-1:0][DATA_W-1:0] regs_q;

  // Index 0 is the accumulator; the others hold preset constants.
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_acc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    regs_q[i] <= REG_INIT[i*DATA_W +: DATA_W];
        else if (a_we) regs_q[i] <= a_wdata;
      end
    end else begin : g_const
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[i] <= REG_INIT[i*DATA_W +: DATA_W];
      end
    end
  end

  assign src_data  = regs_q[src_idx];
  assign dbg_data  = regs_q[dbg_idx];
  assign regs_flat = regs_q;
endmodule

// File: rtl/ldmode_ctrl.sv
module ldmode_ctrl
  import ldmode_pkg::*;
#(
  parameter int PC_W   = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] imem_rdata,
  input  logic [DATA_W-1:0] src_data,
  output logic [PC_W-1:0]   imem_addr,
  output logic [IDX_W-1:0]  src_idx,
  output logic              a_we,
  output logic [DATA_W-1:0] a_wdata,
  output logic              halted,
  output logic              illegal,
  output ctl_state_e        state
);
  ctl_state_e       state_q, state_d;
  logic [PC_W-1:0]  pc_q;
  logic             pc_en;
  logic             mode_q, mode_d, mode_en;
  logic             ill_q, ill_set;
  logic             opnd_out_of_range;

  assign opnd_out_of_range = |imem_rdata[DATA_W-1:IDX_W];

  always_comb begin
    state_d = state_q;
    pc_en   = 1'b0;
    mode_en = 1'b0;
    mode_d  = mode_q;
    ill_set = 1'b0;
    a_we    = 1'b0;
    unique case (state_q)
      ST_FETCH_OP: begin
        pc_en   = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        if (imem_rdata == OPC_NOP) begin
          state_d = ST_FETCH_OP;
        end else if (imem_rdata == OPC_STOP) begin
          state_d = ST_HALT;
        end else if (imem_rdata[DATA_W-1:1] == LD_STEM) begin
          mode_en = 1'b1;
          mode_d  = imem_rdata[0];
          state_d = ST_FETCH_OPND;
        end else begin
          ill_set = 1'b1;
          state_d = ST_HALT;
        end
      end
      ST_FETCH_OPND: begin
        pc_en   = 1'b1;
        state_d = ST_EXECUTE;
      end
      ST_EXECUTE: begin
        if (mode_q && opnd_out_of_range) begin
          ill_set = 1'b1;
          state_d = ST_HALT;
        end else begin
          a_we    = 1'b1;
          state_d = ST_FETCH_OP;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH_OP;
      pc_q    <= '0;
      mode_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pc_en)   pc_q   <= pc_q + 1'b1;
      if (mode_en) mode_q <= mode_d;
      if (ill_set) ill_q  <= 1'b1;
    end
  end

  assign imem_addr = pc_q;
  assign src_idx   = imem_rdata[IDX_W-1:0];
  assign a_wdata   = mode_q ? src_data : imem_rdata;
  assign halted    = (state_q == ST_HALT);
  assign illegal   = ill_q;
  assign state     = state_q;
endmodule

// File: rtl/ldmode_core.sv
module ldmode_core
  import ldmode_pkg::*;
#(
  parameter int PC_W   = 8,
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  parameter logic [NREG*DATA_W-1:0] REG_INIT = 32'h5D3C1B00,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [DATA_W-1:0] imem_rdata,
  input  logic [IDX_W-1:0]  dbg_sel,
  output logic [DATA_W-1:0] dbg_data,
  output logic              halted,
  output logic              illegal
);
  logic                   rst_n_s;
  logic                   a_we;
  logic [DATA_W-1:0]      a_wdata;
  logic [IDX_W-1:0]       src_idx;
  logic [DATA_W-1:0]      src_data;
  logic [NREG*DATA_W-1:0] regs_flat;
  ctl_state_e             ctl_state;

  ldmode_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  ldmode_ctrl #(.PC_W(PC_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .imem_rdata (imem_rdata),
    .src_data   (src_data),
    .imem_addr  (imem_addr),
    .src_idx    (src_idx),
    .a_we       (a_we),
    .a_wdata    (a_wdata),
    .halted     (halted),
    .illegal    (illegal),
    .state      (ctl_state)
  );

  ldmode_regfile #(.DATA_W(DATA_W), .NREG(NREG), .REG_INIT(REG_INIT)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .a_we      (a_we),
    .a_wdata   (a_wdata),
    .src_idx   (src_idx),
    .src_data  (src_data),
    .dbg_idx   (dbg_sel),
    .dbg_data  (dbg_data),
    .regs_flat (regs_flat)
  );
endmodule

// File: rtl/ldmode_core_chk.sv
module ldmode_core_chk
  import ldmode_pkg::*;
#(
  parameter int PC_W   = 8,
  parameter int DATA_W = 8,
  parameter int NREG   = 4
) (
  input logic                   clk,
  input logic                   rst_n_s,
  input logic [PC_W-1:0]        imem_addr,
  input logic                   halted,
  input logic                   illegal,
  input logic [NREG*DATA_W-1:0] regs_flat,
  input ctl_state_e             ctl_state
);
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    halted |=> (halted && $stable(imem_addr)));

  // R7
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    illegal |=> illegal);

  // R4
  illegal_halts_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    illegal |-> halted);

  // R9
  preset_regs_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $stable(regs_flat[NREG*DATA_W-1:DATA_W]));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(imem_addr) |-> (imem_addr == PC_W'($past(imem_addr) + 1'b1)));

  // R2
  acc_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(regs_flat[DATA_W-1:0]) |-> ($past(ctl_state) == ST_EXECUTE));
endmodule

bind ldmode_core ldmode_core_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .NREG(NREG)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .imem_addr (imem_addr),
  .halted    (halted),
  .illegal   (illegal),
  .regs_flat (regs_flat),
  .ctl_state (ctl_state)
);

// File: tb/ldmode_core_bench.sv
module ldmode_core_bench;
  localparam logic [31:0] INIT = 32'h5D3C1B00;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] imem_addr;
  logic [7:0] imem_rdata;
  logic [1:0] dbg_sel;
  logic [7:0] dbg_data;
  logic       halted;
  logic       illegal;
  logic [7:0] mem [256];
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ldmode_core #(.REG_INIT(INIT)) u_ldmode_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dbg_sel    (dbg_sel),
    .dbg_data   (dbg_data),
    .halted     (halted),
    .illegal    (illegal)
  );

  always @(posedge clk) imem_rdata <= mem[imem_addr];

  function automatic logic [7:0] init_of(int i);
    return INIT[i*8 +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [7:0] v);
    dbg_sel = idx[1:0];
    #1;
    v = dbg_data;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
  endtask

  // Reset, run until halted, return cycles from release to halt.
  task automatic run(output int cyc);
    logic [7:0] pc_at;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(halted, "R8 run ends", halted, 1);
    pc_at = imem_addr;
    repeat (3) @(negedge clk);
    chk(halted && imem_addr == pc_at, "R10 stop frozen", imem_addr, pc_at);
  endtask

  task automatic check_state(input string req, input logic [7:0] a_exp,
                             input logic [7:0] pc_exp, input bit ill_exp);
    logic [7:0] v;
    rd(0, v);
    chk(v == a_exp, {req, " A"}, v, a_exp);
    chk(imem_addr == pc_exp, {req, " addr"}, imem_addr, pc_exp);
    chk(illegal == ill_exp, {req, " illegal"}, illegal, ill_exp);
    for (int r = 1; r < 4; r++) begin
      rd(r, v);
      chk(v == init_of(r), "R9 preset", v, init_of(r));
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0, c1;
    logic [7:0] v, a_exp, pc_exp;
    bit ill;
    dbg_sel = '0;
    rst_n = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(imem_addr == 0, "R1 addr", imem_addr, 0);
    chk(!halted, "R1 halted", halted, 0);
    chk(!illegal, "R1 illegal", illegal, 0);
    for (int r = 0; r < 4; r++) begin
      rd(r, v);
      chk(v == init_of(r), "R1 reg", v, init_of(r));
    end

    // R6: bare stop
    clear_mem();
    run(c0);
    check_state("R6", 8'h00, 8'h01, 1'b0);

    // R5/R8: three NOPs then stop, 2 cycles each
    clear_mem();
    mem[0] = 8'h00; mem[1] = 8'h00; mem[2] = 8'h00;
    run(c1);
    chk(c1 - c0 == 6, "R8 nop cycles", c1 - c0, 6);
    check_state("R5", 8'h00, 8'h04, 1'b0);

    // R8: load takes 4 cycles
    clear_mem();
    mem[0] = 8'hAA; mem[1] = 8'h5A;
    run(c1);
    chk(c1 - c0 == 4, "R8 load cycles", c1 - c0, 4);

    // R2 vs R3: same operand 0x02, different mode
    clear_mem();
    mem[0] = 8'hAA; mem[1] = 8'h02;
    run(c1);
    check_state("R2 op02", 8'h02, 8'h03, 1'b0);
    clear_mem();
    mem[0] = 8'hAB; mem[1] = 8'h02;
    run(c1);
    check_state("R3 op02", init_of(2), 8'h03, 1'b0);

    // R2 sweep over every immediate
    for (int x = 0; x < 256; x++) begin
      clear_mem();
      mem[0] = 8'hAA; mem[1] = x[7:0];
      run(c1);
      check_state("R2", x[7:0], 8'h03, 1'b0);
    end

    // R3/R4 sweep over every register-mode operand
    for (int x = 0; x < 256; x++) begin
      clear_mem();
      mem[0] = 8'hAA; mem[1] = 8'h99; mem[2] = 8'hAB; mem[3] = x[7:0];
      run(c1);
      if (x < 4) check_state("R3", (x == 0) ? 8'h99 : init_of(x), 8'h05, 1'b0);
      else       check_state("R4", 8'h99, 8'h04, 1'b1);
    end

    // R7 sweep over every opcode byte, followed by 0x07 then stops
    for (int x = 0; x < 256; x++) begin
      clear_mem();
      mem[0] = x[7:0]; mem[1] = 8'h07;
      run(c1);
      case (x)
        8'h00:   begin a_exp = 8'h00; pc_exp = 8'h02; ill = 1'b1; end
        8'hAA:   begin a_exp = 8'h07; pc_exp = 8'h03; ill = 1'b0; end
        8'hAB:   begin a_exp = 8'h00; pc_exp = 8'h02; ill = 1'b1; end
        8'hFF:   begin a_exp = 8'h00; pc_exp = 8'h01; ill = 1'b0; end
        default: begin a_exp = 8'h00; pc_exp = 8'h01; ill = 1'b1; end
      endcase
      check_state("R7", a_exp, pc_exp, ill);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule